// File: doc/BRIEF.md
# Legacy Memory Attribute and SMRAM Router

This block sits in the memory decode path of a host bridge and decides, for every access into the legacy region between 640 KB and 1 MB, whether the access is served by DRAM or forwarded to the PCI bus. The decision for each access depends on three things: the access address, whether it is a read or a write, and whether the processor is in system management mode (SMM). Firmware programs the routing through a byte-wide configuration port. The port holds seven attribute bytes and one SMRAM control byte.

The upper 256 KB of the legacy region is split into thirteen segments. The BIOS segment, index 0, covers 0xF0000–0xFFFFF. Twelve expansion segments of 16 KB each, indices 1 to 12, fill 0xC0000–0xEFFFF. Each segment has its own four-bit attribute field. The 128 KB video window, 0xA0000–0xBFFFF, is controlled by the SMRAM control byte instead, with separate rules for normal accesses and for SMM accesses.

Configuration writes land in a staging copy of the registers. A small commit state machine then copies the staging copy into the working copy that the address decoder uses. It has two states:
- CFG_IDLE waits. On a write that hits a mapped offset it moves to CFG_COMMIT.
- CFG_COMMIT copies the staging registers into the working registers. If another mapped write arrives in the same cycle it stays in CFG_COMMIT; otherwise it returns to CFG_IDLE.

Top module: `legacy_mem_router`

## Requirements
- R1: After reset the attribute bytes at offsets 0x59–0x5F read 0x00 and the SMRAM control byte at offset 0x72 reads 0x02, so every access in 0xA0000–0xFFFFF (read or write, SMM or not) routes to PCI.
- R2: A configuration read returns its data on cfg_rdata in the cycle after cfg_rd_en is sampled. Offsets 0x59–0x5F and 0x72 return the stored byte; any other offset returns 0x00.
- R3: A write to any offset other than 0x59–0x5F and 0x72 changes no register and no routing decision, including offsets 0x58, 0x60, 0x71, 0x73 and 0xD9.
- R4: The BIOS segment takes its field from bits 7:4 of offset 0x59; bits 3:0 of 0x59 are unused. Expansion segment s (1–12) starts at 0xC0000 + (s−1)·0x4000 and takes its field from offset 0x59 + (s+1)/2, using bits 7:4 when s is odd and bits 3:0 when s is even.
- R5: Within a four-bit field, bit 0 sends reads to DRAM and bit 1 sends writes to DRAM (00 all to PCI, 01 read-only, 10 write-only, 11 read/write). Field bits 3:2 have no effect. An access whose bit is clear goes to PCI.
- R6: A non-SMM access to 0xA0000–0xBFFFF goes to DRAM when bit 6 (open) of the SMRAM control byte is set, and to PCI when it is clear.
- R7: An SMM access to 0xA0000–0xBFFFF goes to DRAM when bit 3 (global enable) of the SMRAM control byte is set, and to PCI when it is clear; bit 6 does not affect it.
- R8: Accesses below 0xA0000 or at or above 0x100000 raise route_valid with both route_dram and route_pci low.
- R9: route_valid is high exactly in the cycle after a sampled req_valid. route_dram and route_pci are never high together, and inside 0xA0000–0xFFFFF exactly one of them is high.
- R10: A mapped configuration write sampled at edge k affects requests sampled at edge k+2 and later; a request sampled at edge k+1 still sees the previous setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_rd_en | input | 1 | Configuration byte read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, registered |
| req_valid | input | 1 | Memory access present |
| req_addr | input | ADDR_W | Memory access byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_smm | input | 1 | Access issued in system management mode |
| route_valid | output | 1 | Routing result present |
| route_dram | output | 1 | Access is served by DRAM |
| route_pci | output | 1 | Access is forwarded to PCI |

## Verification
The bench first sweeps a single enabled field across all twelve expansion segments. At each step it probes the first and last byte of the enabled segment and of both neighbours, which catches any error in the offset, nibble or boundary mapping. It then runs every field encoding, including values that set only the ignored bits, as both a read and a write. This separates the read-enable bit from the write-enable bit. The four combinations of the open and enable bits are tried with SMM asserted and deasserted, which shows which bit governs which kind of access. Finally, requests issued one and two cycles after a write expose the commit latency, and zero writes to neighbouring unmapped offsets show whether any of them alias onto a real register.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [0:0] {
        CFG_IDLE   = 1'b0,
        CFG_COMMIT = 1'b1
    } cfg_state_e;

    typedef struct packed {
        logic to_dram;
        logic to_pci;
    } route_t;

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs
    import lmd_pkg::*;
#(
    parameter int          CFG_AW         = 8,
    parameter int          NUM_ATTR_BYTES = 7,
    parameter logic [7:0]  ATTR_BASE      = 8'h59,
    parameter logic [7:0]  SMRAM_OFS      = 8'h72,
    parameter logic [7:0]  SMRAM_RST      = 8'h02
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr_en,
    input  logic                        cfg_rd_en,
    input  logic [CFG_AW-1:0]           cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    output logic [7:0]                  cfg_rdata,
    output logic [NUM_ATTR_BYTES*8-1:0] eff_attr,
    output logic [7:0]                  eff_smram
);

    logic [7:0]        stage_attr [NUM_ATTR_BYTES];
    logic [7:0]        work_attr  [NUM_ATTR_BYTES];
    logic [7:0]        stage_smram;
    logic [7:0]        work_smram;
    logic [CFG_AW-1:0] ofs_rel;
    logic              attr_hit;
    logic              smram_hit;
    logic              map_wr;
    logic              commit_en;
    logic [7:0]        rd_mux;
    cfg_state_e        state_q, state_d;

    // offset decode: a relative offset below the base wraps to a large value
    assign ofs_rel   = cfg_addr - CFG_AW'(ATTR_BASE);
    assign attr_hit  = (ofs_rel < CFG_AW'(NUM_ATTR_BYTES));
    assign smram_hit = (cfg_addr == CFG_AW'(SMRAM_OFS));
    assign map_wr    = cfg_wr_en && (attr_hit || smram_hit);

    // commit state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_IDLE:   if (map_wr) state_d = CFG_COMMIT;
            CFG_COMMIT: state_d = map_wr ? CFG_COMMIT : CFG_IDLE;
            default:    state_d = CFG_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        commit_en = 1'b0;
        unique case (state_q)
            CFG_IDLE:   commit_en = 1'b0;
            CFG_COMMIT: commit_en = 1'b1;
            default:    commit_en = 1'b0;
        endcase
    end

    // staging and working copies
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_ATTR_BYTES; b++) begin
                stage_attr[b] <= '0;
                work_attr[b]  <= '0;
            end
            stage_smram <= SMRAM_RST;
            work_smram  <= SMRAM_RST;
        end else begin
            for (int b = 0; b < NUM_ATTR_BYTES; b++) begin
                if (cfg_wr_en && attr_hit && (ofs_rel == CFG_AW'(b)))
                    stage_attr[b] <= cfg_wdata;
                if (commit_en)
                    work_attr[b] <= stage_attr[b];
            end
            if (cfg_wr_en && smram_hit) stage_smram <= cfg_wdata;
            if (commit_en)              work_smram  <= stage_smram;
        end
    end

    // read path
    always_comb begin
        rd_mux = '0;
        if (smram_hit) rd_mux = stage_smram;
        for (int b = 0; b < NUM_ATTR_BYTES; b++)
            if (attr_hit && (ofs_rel == CFG_AW'(b))) rd_mux = stage_attr[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cfg_rdata <= '0;
        else if (cfg_rd_en) cfg_rdata <= rd_mux;
    end

    generate
        for (genvar g = 0; g < NUM_ATTR_BYTES; g++) begin : g_flat
            assign eff_attr[g*8 +: 8] = work_attr[g];
        end
    endgenerate

    assign eff_smram = work_smram;

endmodule

// File: rtl/lmd_seg_lookup.sv
module lmd_seg_lookup #(
    parameter int NUM_ATTR_BYTES = 7,
    localparam int NUM_SEGS      = 2*NUM_ATTR_BYTES - 1
) (
    input  logic [NUM_ATTR_BYTES*8-1:0] eff_attr,
    output logic [NUM_SEGS-1:0]         seg_rd_ok,
    output logic [NUM_SEGS-1:0]         seg_wr_ok
);

    logic unused_attr;
    assign unused_attr = ^eff_attr;

    generate
        for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
            localparam int BYTE_IDX = (s + 1) / 2;
            // segment 0 and odd segments take the upper nibble
            localparam int NIB_LSB  = ((s == 0) || (s % 2 == 1)) ? 4 : 0;
            localparam int BASE_BIT = BYTE_IDX*8 + NIB_LSB;
            assign seg_rd_ok[s] = eff_attr[BASE_BIT];
            assign seg_wr_ok[s] = eff_attr[BASE_BIT + 1];
        end
    endgenerate

endmodule

// File: rtl/lmd_route.sv
module lmd_route
    import lmd_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          NUM_SEGS  = 13,
    parameter int          SEG_SHIFT = 14,
    parameter logic [31:0] WIN_LO    = 32'h000A_0000,
    parameter logic [31:0] EXP_LO    = 32'h000C_0000,
    parameter logic [31:0] BIOS_LO   = 32'h000F_0000,
    parameter logic [31:0] LEG_TOP   = 32'h0010_0000,
    parameter int          OPEN_BIT  = 6,
    parameter int          GEN_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    input  logic [NUM_SEGS-1:0] seg_rd_ok,
    input  logic [NUM_SEGS-1:0] seg_wr_ok,
    input  logic [7:0]        smram_ctl,
    output logic              route_valid,
    output logic              route_dram,
    output logic              route_pci
);

    logic [NUM_SEGS-1:0] seg_hit;
    logic                in_win;
    logic                in_seg;
    logic                seg_ok;
    logic                win_ok;
    route_t              dec;
    logic                unused_ctl;

    assign unused_ctl = ^smram_ctl;

    generate
        for (genvar s = 0; s < NUM_SEGS; s++) begin : g_hit
            if (s == 0) begin : g_bios
                assign seg_hit[s] = (req_addr >= ADDR_W'(BIOS_LO)) &&
                                    (req_addr <  ADDR_W'(LEG_TOP));
            end else begin : g_exp
                localparam logic [31:0] LO = EXP_LO + (32'(s - 1) << SEG_SHIFT);
                localparam logic [31:0] HI = LO + (32'd1 << SEG_SHIFT);
                assign seg_hit[s] = (req_addr >= ADDR_W'(LO)) &&
                                    (req_addr <  ADDR_W'(HI));
            end
        end
    endgenerate

    assign in_win = (req_addr >= ADDR_W'(WIN_LO)) && (req_addr < ADDR_W'(EXP_LO));
    assign in_seg = |seg_hit;
    assign seg_ok = req_write ? |(seg_hit & seg_wr_ok) : |(seg_hit & seg_rd_ok);
    assign win_ok = req_smm ? smram_ctl[GEN_BIT] : smram_ctl[OPEN_BIT];

    always_comb begin
        dec = '0;
        if (in_win) begin
            dec.to_dram = win_ok;
            dec.to_pci  = !win_ok;
        end else if (in_seg) begin
            dec.to_dram = seg_ok;
            dec.to_pci  = !seg_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_valid <= 1'b0;
            route_dram  <= 1'b0;
            route_pci   <= 1'b0;
        end else begin
            route_valid <= req_valid;
            route_dram  <= req_valid && dec.to_dram;
            route_pci   <= req_valid && dec.to_pci;
        end
    end

endmodule

// File: rtl/legacy_mem_router.sv
module legacy_mem_router
    import lmd_pkg::*;
#(
    parameter int          ADDR_W         = 32,
    parameter int          NUM_ATTR_BYTES = 7,
    parameter logic [7:0]  ATTR_BASE      = 8'h59,
    parameter logic [7:0]  SMRAM_OFS      = 8'h72,
    parameter logic [7:0]  SMRAM_RST      = 8'h02,
    parameter int          SEG_SHIFT      = 14,
    parameter int          OPEN_BIT       = 6,
    parameter int          GEN_BIT        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_smm,
    output logic              route_valid,
    output logic              route_dram,
    output logic              route_pci
);

    localparam int NUM_SEGS = 2*NUM_ATTR_BYTES - 1;

    logic [NUM_ATTR_BYTES*8-1:0] eff_attr;
    logic [7:0]                  eff_smram;
    logic [NUM_SEGS-1:0]         seg_rd_ok;
    logic [NUM_SEGS-1:0]         seg_wr_ok;

    lmd_cfg_regs #(
        .CFG_AW         (8),
        .NUM_ATTR_BYTES (NUM_ATTR_BYTES),
        .ATTR_BASE      (ATTR_BASE),
        .SMRAM_OFS      (SMRAM_OFS),
        .SMRAM_RST      (SMRAM_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_rd_en (cfg_rd_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .eff_attr  (eff_attr),
        .eff_smram (eff_smram)
    );

    lmd_seg_lookup #(
        .NUM_ATTR_BYTES (NUM_ATTR_BYTES)
    ) u_lookup (
        .eff_attr  (eff_attr),
        .seg_rd_ok (seg_rd_ok),
        .seg_wr_ok (seg_wr_ok)
    );

    lmd_route #(
        .ADDR_W    (ADDR_W),
        .NUM_SEGS  (NUM_SEGS),
        .SEG_SHIFT (SEG_SHIFT),
        .OPEN_BIT  (OPEN_BIT),
        .GEN_BIT   (GEN_BIT)
    ) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_smm     (req_smm),
        .seg_rd_ok   (seg_rd_ok),
        .seg_wr_ok   (seg_wr_ok),
        .smram_ctl   (eff_smram),
        .route_valid (route_valid),
        .route_dram  (route_dram),
        .route_pci   (route_pci)
    );

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
    parameter int         ADDR_W    = 32,
    parameter logic [7:0] SMRAM_OFS = 8'h72,
    parameter int         GEN_BIT   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_addr,
    input logic [7:0]        cfg_wdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_smm,
    input logic [7:0]        eff_smram,
    input logic              route_valid,
    input logic              route_dram,
    input logic              route_pci
);

    logic in_win;
    logic in_legacy;
    logic above_top;
    assign in_win    = (req_addr >= ADDR_W'(32'h000A_0000)) && (req_addr < ADDR_W'(32'h000C_0000));
    assign in_legacy = (req_addr >= ADDR_W'(32'h000A_0000)) && (req_addr < ADDR_W'(32'h0010_0000));
    assign above_top = (req_addr >= ADDR_W'(32'h0010_0000));

    p_sel_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(route_dram && route_pci));

    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> route_valid);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!route_valid && !route_dram && !route_pci));

    p_legacy_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_legacy) |=> $onehot({route_dram, route_pci}));

    p_outside_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && above_top) |=> (route_valid && !route_dram && !route_pci));

    p_smm_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && in_win && req_smm && !eff_smram[GEN_BIT]) |=> route_pci);

    p_commit_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == SMRAM_OFS) |=> ##1 (eff_smram == $past(cfg_wdata, 2)));

endmodule

bind legacy_mem_router lmd_checker #(
    .ADDR_W    (ADDR_W),
    .SMRAM_OFS (SMRAM_OFS),
    .GEN_BIT   (GEN_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_smm     (req_smm),
    .eff_smram   (eff_smram),
    .route_valid (route_valid),
    .route_dram  (route_dram),
    .route_pci   (route_pci)
);

// File: tb/tb_legacy_mem_router.sv
module tb_legacy_mem_router;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en, cfg_rd_en;
    logic [7:0]  cfg_addr, cfg_wdata, cfg_rdata;
    logic        req_valid, req_write, req_smm;
    logic [31:0] req_addr;
    logic        route_valid, route_dram, route_pci;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          d;
        bit          p;
        logic [31:0] addr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [7:0] m_attr [7];
    logic [7:0] m_smram;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_mem_router dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_smm(req_smm), .route_valid(route_valid),
        .route_dram(route_dram), .route_pci(route_pci)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input bit wr, input bit smm,
                                  output bit d, output bit p);
        int s;
        logic [3:0] nib;
        bit ok;
        d = 1'b0; p = 1'b0;
        if (a >= 32'hA0000 && a < 32'hC0000) begin
            ok = smm ? m_smram[3] : m_smram[6];
            d = ok; p = !ok;
        end else if (a >= 32'hC0000 && a < 32'h100000) begin
            s   = (a >= 32'hF0000) ? 0 : 1 + int'((a - 32'hC0000) >> 14);
            nib = (s == 0 || (s % 2) == 1) ? m_attr[(s+1)/2][7:4] : m_attr[(s+1)/2][3:0];
            ok  = wr ? nib[1] : nib[0];
            d = ok; p = !ok;
        end
    endfunction

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (route_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "result without request", 32'(route_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({route_dram, route_pci} == {e.d, e.p}, e.tag,
                          $sformatf("route {dram,pci} at %h", e.addr),
                          32'({route_dram, route_pci}), 32'({e.d, e.p}));
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
        cfg_wr_en = 1'b0; cfg_rd_en = 1'b0; req_valid = 1'b0;
    endtask

    task automatic send_exp(input logic [31:0] a, input bit wr, input bit smm,
                            input bit d, input bit p, input string tag);
        exp_t e;
        e.d = d; e.p = p; e.addr = a; e.tag = tag;
        sb.push_back(e);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_smm = smm;
        step();
    endtask

    task automatic send(input logic [31:0] a, input bit wr, input bit smm, input string tag);
        bit d, p;
        model(a, wr, smm, d, p);
        send_exp(a, wr, smm, d, p, tag);
    endtask

    task automatic cfg_write_raw(input logic [7:0] ofs, input logic [7:0] val);
        cfg_wr_en = 1'b1; cfg_addr = ofs; cfg_wdata = val;
        step();
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] val);
        cfg_write_raw(ofs, val);
        if (ofs >= 8'h59 && ofs <= 8'h5F) m_attr[ofs - 8'h59] = val;
        if (ofs == 8'h72) m_smram = val;
        step();
    endtask

    task automatic cfg_read(input logic [7:0] ofs, input logic [7:0] exp, input string tag);
        cfg_rd_en = 1'b1; cfg_addr = ofs;
        step();
        check(cfg_rdata == exp, tag, $sformatf("read offset %h", ofs),
              32'(cfg_rdata), 32'(exp));
    endtask

    task automatic drain(input string tag);
        repeat (3) step();
        check(sb.size() == 0, tag, "results outstanding", 32'(sb.size()), 32'd0);
        check(route_valid == 1'b0, tag, "route_valid while idle", 32'(route_valid), 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit d, p;
        logic [7:0] v;
        cfg_wr_en = 0; cfg_rd_en = 0; cfg_addr = 0; cfg_wdata = 0;
        req_valid = 0; req_addr = 0; req_write = 0; req_smm = 0;
        for (int b = 0; b < 7; b++) m_attr[b] = 8'h00;
        m_smram = 8'h02;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1: reset register values and all-PCI routing
        for (int b = 0; b < 7; b++) cfg_read(8'h59 + 8'(b), 8'h00, "R1");
        cfg_read(8'h72, 8'h02, "R1");
        cfg_read(8'h60, 8'h00, "R2");
        send(32'hF0000, 0, 0, "R1"); send(32'hFFFFF, 1, 1, "R1");
        send(32'hC0000, 0, 0, "R1"); send(32'hEFFFF, 1, 0, "R1");
        send(32'hA0000, 0, 0, "R1"); send(32'hBFFFF, 1, 1, "R1");
        drain("R9");

        // R4: low nibble of the BIOS byte is unused
        cfg_write(8'h59, 8'h03);
        cfg_read(8'h59, 8'h03, "R2");
        send(32'hF0000, 0, 0, "R4"); send(32'hF8000, 1, 0, "R4");
        cfg_write(8'h59, 8'h30);
        send(32'hF0000, 0, 0, "R4"); send(32'hFFFFF, 1, 0, "R4");
        send(32'hEFFFF, 0, 0, "R4");
        drain("R4");

        // R4: walk a single enabled field through the expansion segments
        for (int s = 1; s <= 12; s++) begin
            for (int b = 0; b < 7; b++) cfg_write(8'h59 + 8'(b), 8'h00);
            cfg_write(8'h59 + 8'((s + 1) / 2), (s % 2 == 1) ? 8'h30 : 8'h03);
            for (int n = s - 1; n <= s + 1; n++) begin
                if (n >= 1 && n <= 12) begin
                    send(32'hC0000 + 32'((n - 1) * 32'h4000), 0, 0, "R4");
                    send(32'hC0000 + 32'((n - 1) * 32'h4000) + 32'h3FFF, 1, 0, "R4");
                end
            end
        end
        drain("R4");

        // R5: field encodings including ignored upper bits
        for (int e = 0; e < 16; e++) begin
            v = 8'(e);
            cfg_write(8'h5A, {v[3:0], 4'h0});
            send(32'hC0000, 0, 0, "R5");
            send(32'hC1234, 1, 0, "R5");
            send(32'hC4000, 0, 0, "R5");
        end
        drain("R5");

        // R6 / R7: open and global-enable combinations
        for (int c = 0; c < 4; c++) begin
            cfg_write(8'h72, {1'b0, c[1], 2'b00, c[0], 3'b010});
            cfg_read(8'h72, m_smram, "R2");
            send(32'hA0000, 0, 0, "R6"); send(32'hBFFFF, 1, 0, "R6");
            send(32'hA8000, 0, 1, "R7"); send(32'hBFFFF, 1, 1, "R7");
        end
        drain("R7");

        // R8: outside the legacy region, with everything enabled
        for (int b = 0; b < 7; b++) cfg_write(8'h59 + 8'(b), 8'hFF);
        cfg_write(8'h72, 8'h48);
        send(32'h00000, 0, 0, "R8"); send(32'h9FFFF, 1, 1, "R8");
        send(32'h100000, 0, 0, "R8"); send(32'hFFFFFFFF, 1, 1, "R8");
        send(32'hA0000, 0, 0, "R8"); send(32'hEFFFF, 1, 0, "R8");
        send(32'hF0000, 0, 0, "R8"); send(32'hFFFFF, 1, 0, "R8");
        drain("R8");

        // R3: writes of zero to unmapped offsets leave everything alone
        cfg_write(8'h58, 8'h00); cfg_write(8'h60, 8'h00);
        cfg_write(8'h71, 8'h00); cfg_write(8'h73, 8'h00);
        cfg_write(8'hD9, 8'h00);
        cfg_read(8'h59, 8'hFF, "R3"); cfg_read(8'h5F, 8'hFF, "R3");
        cfg_read(8'h72, 8'h48, "R3");
        cfg_read(8'h58, 8'h00, "R3"); cfg_read(8'h73, 8'h00, "R3");
        send(32'hF0000, 0, 0, "R3"); send(32'hC0000, 1, 0, "R3");
        send(32'hEC000, 0, 0, "R3"); send(32'hA0000, 0, 0, "R3");
        drain("R3");

        // R10: commit latency
        cfg_write_raw(8'h72, 8'h00);
        model(32'hA0000, 0, 0, d, p);
        send_exp(32'hA0000, 0, 0, d, p, "R10");
        m_smram = 8'h00;
        send(32'hA0000, 0, 0, "R10");
        send(32'hA0000, 0, 1, "R10");
        cfg_write_raw(8'h59, 8'h00);
        model(32'hF0000, 0, 0, d, p);
        send_exp(32'hF0000, 0, 0, d, p, "R10");
        m_attr[0] = 8'h00;
        send(32'hF0000, 0, 0, "R10");
        drain("R10");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule